// File: doc/BRIEF.md
# Software-Managed Translation Buffer Array

This block holds a small, fully associative table of address translations that software maintains by hand. Software fills a set of staging values (a virtual page tag, the two physical page descriptors, a page size mask and an index) and then issues one of four commands. Probe searches the table for the staged tag. Write-indexed stores the staged values at a slot named by the index. Write-random stores them at a slot picked by an external random source. Read loads the staging values back from a slot.

Each slot maps a pair of adjacent virtual pages, an even page and an odd page, to two physical frames. The slot keeps one tag (the upper virtual page-pair number together with an 8-bit address space identifier), one global flag shared by both pages, the page mask, and for each page a frame number, a valid flag, a dirty flag and a 3-bit cache attribute. Every command finishes in one cycle. The updated staging values appear on the outputs together with a one-cycle completion pulse. A read that replaces the current address space identifier also raises a flush pulse, so that translations cached downstream can be discarded.

Top module: `tlb_array`

## Requirements
- R1: `done` is high for exactly the one cycle after each cycle with `cmd_valid` high, and is low in every other cycle.
- R2: Write-indexed (`cmd_op`=1) stores the slot at `index_in & (N_ENTRIES-1)`. The stored fields are the tag from `entry_hi_in[31:13]`, the identifier from `entry_hi_in[7:0]` and the page mask from `page_mask_in[24:13]`.
- R3: Write-random (`cmd_op`=2) stores the slot at `rand_idx` and ignores `index_in`.
- R4: The slot's global flag is `entry_lo0_in[0] & entry_lo1_in[0]`. A read returns that combined flag in bit 0 of both descriptors.
- R5: Descriptor layout, for both pages: bit 1 is valid, bit 2 is dirty, bits 5:3 are the cache attribute and bits 29:6 are the frame number. A read returns these fields in the same positions, with bits 31:30 at zero.
- R6: A probe (`cmd_op`=0) that hits sets `index_out` to the lowest-numbered matching slot, with all other bits zero. A slot matches when its tag equals `entry_hi_in[31:13]` and, in addition, either its global flag is set or its identifier equals `entry_hi_in[7:0]`.
- R7: A slot whose global flag is set matches a probe whatever identifier the probe carries. A slot whose flag is clear needs the identifiers to be equal.
- R8: A probe that misses sets `index_out` to `index_in` with bit 31 forced to one.
- R9: A read (`cmd_op`=3) of slot `index_in & (N_ENTRIES-1)` returns the following. `entry_hi_out` is the tag in bits 31:13 and the identifier in bits 7:0, with bits 12:8 at zero. `page_mask_out` is the mask in bits 24:13 and zero elsewhere. `index_out` equals `index_in`.
- R10: `asid_flush` goes high together with `done` only after a read whose slot identifier differs from `entry_hi_in[7:0]`. It is low in every other cycle.
- R11: After reset every slot has all fields at zero, so every valid flag is clear. All outputs are zero.
- R12: Probe and both writes pass `entry_hi_in`, `entry_lo0_in`, `entry_lo1_in` and `page_mask_in` unchanged to the outputs. Both writes also pass `index_in` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 2 | 0 probe, 1 write-indexed, 2 write-random, 3 read |
| entry_hi_in | input | 32 | Staged tag: page-pair number and identifier |
| entry_lo0_in | input | 32 | Staged even-page descriptor |
| entry_lo1_in | input | 32 | Staged odd-page descriptor |
| page_mask_in | input | 32 | Staged page mask |
| index_in | input | 32 | Staged slot index |
| rand_idx | input | 4 | Slot chosen for write-random |
| entry_hi_out | output | 32 | Updated tag staging value |
| entry_lo0_out | output | 32 | Updated even-page descriptor |
| entry_lo1_out | output | 32 | Updated odd-page descriptor |
| page_mask_out | output | 32 | Updated page mask |
| index_out | output | 32 | Updated index, bit 31 flags a probe miss |
| done | output | 1 | One-cycle completion pulse |
| asid_flush | output | 1 | Pulse when a read changes the identifier |

## Verification
The assertions check, in every cycle, the timing of the completion pulse, that a flush never appears without completion, that a write lands in the addressed slot, that writes leave the index unchanged, and that a probe result is either a slot number in range or a flagged miss. Only the bench scenarios can show the following: that the lowest of several matching slots wins, that the global flag overrides the identifier, that descriptor fields come back in the right bit positions, and that the flush depends on the identifier comparison. The bench checks these against a model of the table that it keeps itself.

// File: rtl/tlb_pkg.sv
// Shared types and field helpers for the translation buffer array.
// Assumes 32-bit staging values with the page-pair tag at bit 13 upward.
package tlb_pkg;
    localparam int VPN2_W   = 19;
    localparam int ASID_W   = 8;
    localparam int PFN_W    = 24;
    localparam int MASK_W   = 12;
    localparam int CATTR_W  = 3;
    localparam int VPN2_LSB = 13;
    localparam int MASK_LSB = 13;
    localparam int PFN_LSB  = 6;

    typedef enum logic [1:0] {
        OP_PROBE  = 2'd0,
        OP_WR_IDX = 2'd1,
        OP_WR_RND = 2'd2,
        OP_READ   = 2'd3
    } tlb_op_e;

    typedef struct packed {
        logic               v;
        logic               d;
        logic [CATTR_W-1:0] c;
        logic [PFN_W-1:0]   pfn;
    } page_attr_t;

    typedef struct packed {
        logic [VPN2_W-1:0] vpn2;
        logic [ASID_W-1:0] asid;
        logic              g;
        logic [MASK_W-1:0] mask;
        page_attr_t        even;
        page_attr_t        odd;
    } tlb_entry_t;

    // Pull the per-page fields out of a staged descriptor.
    function automatic page_attr_t lo_unpack(input logic [31:0] lo);
        page_attr_t a;
        a.v   = lo[1];
        a.d   = lo[2];
        a.c   = lo[5:3];
        a.pfn = lo[PFN_LSB +: PFN_W];
        return a;
    endfunction

    // Rebuild a descriptor from stored fields plus the shared global flag.
    function automatic logic [31:0] lo_pack(input logic g, input page_attr_t a);
        logic [31:0] r;
        r = '0;
        r[0]   = g;
        r[1]   = a.v;
        r[2]   = a.d;
        r[5:3] = a.c;
        r[PFN_LSB +: PFN_W] = a.pfn;
        return r;
    endfunction

    // Form a whole slot from the four staging values.
    function automatic tlb_entry_t entry_build(input logic [31:0] hi, input logic [31:0] lo0,
                                               input logic [31:0] lo1, input logic [31:0] pm);
        tlb_entry_t e;
        e.vpn2 = hi[VPN2_LSB +: VPN2_W];
        e.asid = hi[ASID_W-1:0];
        e.g    = lo0[0] & lo1[0];
        e.mask = pm[MASK_LSB +: MASK_W];
        e.even = lo_unpack(lo0);
        e.odd  = lo_unpack(lo1);
        return e;
    endfunction
endpackage

// File: rtl/tlb_entry_store.sv
// Register file of translation slots with one write port, one read port
// and a flat view of every slot for the parallel probe.
// Assumes a single write per cycle; reads see the contents before the write.
module tlb_entry_store
    import tlb_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    localparam int IDX_W = $clog2(N_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  tlb_entry_t       wdata,
    input  logic [IDX_W-1:0] raddr,
    output tlb_entry_t       rdata,
    output tlb_entry_t       slots [N_ENTRIES]
);
    tlb_entry_t mem [N_ENTRIES];

    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_slot
        // Clear the slot on reset, load it when addressed by a write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[i] <= '0;
            end else if (we && waddr == IDX_W'(i)) begin
                mem[i] <= wdata;
            end
        end
        assign slots[i] = mem[i];
    end

    // Combinational read port.
    assign rdata = mem[raddr];

    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/tlb_probe_match.sv
// Parallel tag comparators feeding a lowest-index priority encoder.
// Assumes the key is stable for the cycle in which the probe is issued.
module tlb_probe_match
    import tlb_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    localparam int IDX_W = $clog2(N_ENTRIES)
) (
    input  tlb_entry_t        slots [N_ENTRIES],
    input  logic [VPN2_W-1:0] key_vpn2,
    input  logic [ASID_W-1:0] key_asid,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx
);
    logic [N_ENTRIES-1:0] match_vec;

    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_cmp
        assign match_vec[i] = (slots[i].vpn2 == key_vpn2) &&
                              (slots[i].g || slots[i].asid == key_asid);
    end

    // Pick the lowest-numbered matching slot.
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tlb_array.sv
// Top of the software-managed translation buffer: decodes the command,
// drives the slot store and the probe, and registers the staging results.
// Assumes at most one command per cycle; results appear the next cycle.
module tlb_array
    import tlb_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    localparam int IDX_W = $clog2(N_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [31:0]      entry_hi_in,
    input  logic [31:0]      entry_lo0_in,
    input  logic [31:0]      entry_lo1_in,
    input  logic [31:0]      page_mask_in,
    input  logic [31:0]      index_in,
    input  logic [IDX_W-1:0] rand_idx,
    output logic [31:0]      entry_hi_out,
    output logic [31:0]      entry_lo0_out,
    output logic [31:0]      entry_lo1_out,
    output logic [31:0]      page_mask_out,
    output logic [31:0]      index_out,
    output logic             done,
    output logic             asid_flush
);
    localparam logic [31:0] MISS_FLAG = 32'h8000_0000;

    tlb_entry_t       slots [N_ENTRIES];
    tlb_entry_t       rd_ent;
    tlb_entry_t       wr_ent;
    logic             wr_en;
    logic [IDX_W-1:0] wr_addr;
    logic [IDX_W-1:0] sel_idx;
    logic             probe_hit;
    logic [IDX_W-1:0] probe_idx;
    logic [31:0]      rd_hi;
    logic [31:0]      rd_pm;

    // Decode write enable, write slot and the masked index.
    always_comb begin
        sel_idx = index_in[IDX_W-1:0];
        wr_en   = cmd_valid && (cmd_op == OP_WR_IDX || cmd_op == OP_WR_RND);
        wr_addr = (cmd_op == OP_WR_RND) ? rand_idx : sel_idx;
        wr_ent  = entry_build(entry_hi_in, entry_lo0_in, entry_lo1_in, page_mask_in);
    end

    tlb_entry_store #(.N_ENTRIES(N_ENTRIES)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_ent),
        .raddr (sel_idx),
        .rdata (rd_ent),
        .slots (slots)
    );

    tlb_probe_match #(.N_ENTRIES(N_ENTRIES)) u_probe (
        .slots    (slots),
        .key_vpn2 (entry_hi_in[VPN2_LSB +: VPN2_W]),
        .key_asid (entry_hi_in[ASID_W-1:0]),
        .hit      (probe_hit),
        .hit_idx  (probe_idx)
    );

    // Rebuild the tag and mask staging words from the read slot.
    always_comb begin
        rd_hi = '0;
        rd_hi[VPN2_LSB +: VPN2_W] = rd_ent.vpn2;
        rd_hi[ASID_W-1:0]         = rd_ent.asid;
        rd_pm = '0;
        rd_pm[MASK_LSB +: MASK_W] = rd_ent.mask;
    end

    // Register staging results, completion and flush pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry_hi_out  <= '0;
            entry_lo0_out <= '0;
            entry_lo1_out <= '0;
            page_mask_out <= '0;
            index_out     <= '0;
            done          <= 1'b0;
            asid_flush    <= 1'b0;
        end else begin
            done       <= cmd_valid;
            asid_flush <= cmd_valid && cmd_op == OP_READ &&
                          rd_ent.asid != entry_hi_in[ASID_W-1:0];
            if (cmd_valid) begin
                entry_hi_out  <= entry_hi_in;
                entry_lo0_out <= entry_lo0_in;
                entry_lo1_out <= entry_lo1_in;
                page_mask_out <= page_mask_in;
                index_out     <= index_in;
                if (cmd_op == OP_PROBE) begin
                    index_out <= probe_hit ? 32'(probe_idx) : (index_in | MISS_FLAG);
                end else if (cmd_op == OP_READ) begin
                    entry_hi_out  <= rd_hi;
                    entry_lo0_out <= lo_pack(rd_ent.g, rd_ent.even);
                    entry_lo1_out <= lo_pack(rd_ent.g, rd_ent.odd);
                    page_mask_out <= rd_pm;
                end
            end
        end
    end

    p_done_follows_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> done);
    p_done_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !done);
    p_flush_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        asid_flush |-> done);
    p_write_keeps_index_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> index_out == $past(index_in));
    p_miss_flagged_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_PROBE && !probe_hit) |=> index_out[31]);
    p_hit_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_PROBE && probe_hit) |=> index_out < 32'(N_ENTRIES));
endmodule

// File: tb/sim_tlb_array.sv
`timescale 1ns/1ps
// Bench for tlb_array: directed corners plus seeded random commands,
// checked against a bench-side model of the slot table.
module sim_tlb_array;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [31:0] hi_i = '0, lo0_i = '0, lo1_i = '0, pm_i = '0, idx_i = '0;
    logic [3:0]  rnd_i = '0;
    logic [31:0] hi_o, lo0_o, lo1_o, pm_o, idx_o;
    logic        done, flush;

    int n_tests = 0;
    int n_fail  = 0;

    logic [31:0] m_hi [N];
    logic [31:0] m_lo0 [N];
    logic [31:0] m_lo1 [N];
    logic [31:0] m_pm [N];

    always #4 clk = ~clk;

    tlb_array #(.N_ENTRIES(N)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .entry_hi_in(hi_i), .entry_lo0_in(lo0_i), .entry_lo1_in(lo1_i),
        .page_mask_in(pm_i), .index_in(idx_i), .rand_idx(rnd_i),
        .entry_hi_out(hi_o), .entry_lo0_out(lo0_o), .entry_lo1_out(lo1_o),
        .page_mask_out(pm_o), .index_out(idx_o), .done(done), .asid_flush(flush)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // Expected probe result from the model (R6, R7, R8).
    function automatic logic [31:0] exp_probe(input logic [31:0] hi, input logic [31:0] idx);
        for (int i = 0; i < N; i++) begin
            if (m_hi[i][31:13] == hi[31:13] && (m_lo0[i][0] || m_hi[i][7:0] == hi[7:0]))
                return 32'(i);
        end
        return idx | 32'h8000_0000;
    endfunction

    // Issue one command, then compare every output against the model.
    task automatic do_cmd(input logic [1:0] op, input logic [31:0] hi, input logic [31:0] lo0,
                          input logic [31:0] lo1, input logic [31:0] pm,
                          input logic [31:0] idx, input logic [3:0] rnd);
        logic [31:0] e_hi, e_lo0, e_lo1, e_pm, e_idx;
        logic        e_fl, g;
        int          s;
        @(negedge clk);
        chk("R1 idle done", 32'(done), 32'd0);
        cmd_op = op; hi_i = hi; lo0_i = lo0; lo1_i = lo1; pm_i = pm; idx_i = idx; rnd_i = rnd;
        cmd_valid = 1'b1;
        e_hi = hi; e_lo0 = lo0; e_lo1 = lo1; e_pm = pm; e_idx = idx; e_fl = 1'b0;
        s = int'(idx[3:0]);
        case (op)
            2'd0: e_idx = exp_probe(hi, idx);
            2'd3: begin
                e_hi = m_hi[s]; e_lo0 = m_lo0[s]; e_lo1 = m_lo1[s]; e_pm = m_pm[s];
                e_fl = (m_hi[s][7:0] != hi[7:0]);
            end
            default: ;
        endcase
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R1 done", 32'(done), 32'd1);
        chk("R10 flush", 32'(flush), 32'(e_fl));
        chk(op == 2'd3 ? "R9 hi" : "R12 hi", hi_o, e_hi);
        chk(op == 2'd3 ? "R5 lo0" : "R12 lo0", lo0_o, e_lo0);
        chk(op == 2'd3 ? "R4 lo1" : "R12 lo1", lo1_o, e_lo1);
        chk(op == 2'd3 ? "R9 mask" : "R12 mask", pm_o, e_pm);
        chk(op == 2'd0 ? "R6 R8 index" : "R9 index", idx_o, e_idx);
        if (op == 2'd1 || op == 2'd2) begin
            s = (op == 2'd2) ? int'(rnd) : int'(idx[3:0]);
            g = lo0[0] & lo1[0];
            m_hi[s]  = {hi[31:13], 5'b0, hi[7:0]};
            m_lo0[s] = {2'b0, lo0[29:1], g};
            m_lo1[s] = {2'b0, lo1[29:1], g};
            m_pm[s]  = pm & 32'h01FF_E000;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < N; i++) begin
            m_hi[i] = '0; m_lo0[i] = '0; m_lo1[i] = '0; m_pm[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: outputs after reset
        chk("R11 done", 32'(done), 32'd0);
        chk("R11 index", idx_o, 32'd0);
        chk("R11 hi", hi_o, 32'd0);
        // R11: zeroed slots, R8 miss flag keeps index bits
        do_cmd(2'd0, 32'h0000_0000, 0, 0, 0, 32'd9, 0);
        do_cmd(2'd0, 32'h0000_2000, 0, 0, 0, 32'd5, 0);
        do_cmd(2'd3, 32'h0000_0011, 0, 0, 0, 32'd6, 0);
        // R2, R5: index masked to slot count, field layout
        do_cmd(2'd1, 32'hABCD_E0FF | 32'h1F00, 32'hFFFF_FFFE, 32'h2AAA_AAAB,
               32'hFFFF_FFFF, 32'h0000_0023, 4'd0);
        do_cmd(2'd3, 32'h0000_00FF, 0, 0, 0, 32'd3, 0);
        // R3: random slot, index ignored
        do_cmd(2'd2, 32'h1234_6042, 32'h0000_0047, 32'h0000_00C5,
               32'h0000_6000, 32'd1, 4'd12);
        do_cmd(2'd3, 32'h0000_0042, 0, 0, 0, 32'd12, 0);
        do_cmd(2'd3, 32'h0000_0000, 0, 0, 0, 32'd1, 0);
        // R4, R7: global slot ignores identifier, half-global does not
        do_cmd(2'd1, 32'h7000_0010, 32'h0000_0043, 32'h0000_0041, 0, 32'd7, 0);
        do_cmd(2'd0, 32'h7000_0099, 0, 0, 0, 32'd2, 0);
        do_cmd(2'd1, 32'h5000_0010, 32'h0000_0043, 32'h0000_0040, 0, 32'd8, 0);
        do_cmd(2'd0, 32'h5000_0099, 0, 0, 0, 32'd2, 0);
        do_cmd(2'd0, 32'h5000_0010, 0, 0, 0, 32'd2, 0);
        // R6: lowest of two matching slots wins
        do_cmd(2'd1, 32'h3000_0021, 32'h2, 32'h2, 0, 32'd9, 0);
        do_cmd(2'd1, 32'h3000_0021, 32'h6, 32'h6, 0, 32'd4, 0);
        do_cmd(2'd0, 32'h3000_0021, 0, 0, 0, 32'h8000_0000, 0);
        // R10: flush only when the identifier changes
        do_cmd(2'd3, 32'h0000_0021, 0, 0, 0, 32'd4, 0);
        do_cmd(2'd3, 32'h0000_0022, 0, 0, 0, 32'd4, 0);
        // Seeded random mix over a small tag pool to provoke hits
        for (int k = 0; k < 400; k++) begin
            logic [31:0] hi, lo0, lo1;
            hi  = {17'($urandom_range(0, 3)) << 13, 5'($urandom), 8'($urandom_range(0, 3))};
            hi  = {hi[31:13] & 19'h3 , hi[12:0]};
            lo0 = $urandom;
            lo1 = $urandom;
            do_cmd(2'($urandom), hi, lo0, lo1, $urandom, $urandom, 4'($urandom));
        end
        @(negedge clk);
        chk("R1 final idle", 32'(done), 32'd0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule